// File: doc/BRIEF.md
# Mersenne Twister (MT19937) Word Generator

This block produces the MT19937 pseudo-random stream in hardware, one 32-bit word per clock while it is generating. It holds the 624-word generator state in an on-block memory. A small controller sequences two engines over that memory. A fill engine expands a single 32-bit seed into the full state, one word per cycle. A mixing engine twists the state one word per cycle, writes the twisted word back and emits its tempered form.

A single strobe starts the generator from idle, and the seed presented with that strobe is captured. After the 624 fill cycles, one guard cycle passes, and then a run of 624 valid words follows. The generator then refills its state by itself, using the last word it produced as the new seed, and continues to alternate between filling and producing words until reset. Status pulses mark the end of each fill and the final word of each run.

Top module: `mtg_core`

## Requirements
- R1: While reset is held, and in idle after reset until a start strobe arrives, `rnd_vld_o`, `seed_done_o` and `twist_done_o` are low and `rnd_o` is zero; a changing `seed_i` alone causes no activity.
- R2: A clock edge that samples `seed_load_i` high in idle captures `seed_i`. `seed_done_o` is then high for exactly one cycle, following the 624th rising edge after the capturing edge.
- R3: The first word of a run is valid two cycles after `seed_done_o` is high, with one idle guard cycle between them.
- R4: Each run is exactly 624 consecutive cycles with `rnd_vld_o` high.
- R5: The words of a run equal the standard MT19937 outputs for the current seed. The state is filled as s[0] = seed and s[i] = 1812433253·(s[i-1] ^ (s[i-1] >> 30)) + i mod 2^32. Each word is twisted as y = (s[i] & 0x80000000) | (s[i+1 mod 624] & 0x7FFFFFFF), then s[i] = s[i+397 mod 624] ^ (y >> 1) ^ (0x9908B0DF if y bit 0 is 1). The twisted word is tempered by x ^= x>>11; x ^= (x<<7) & 0x9D2C5680; x ^= (x<<15) & 0xEFC60000; x ^= x>>18. For seed 5489 the first three words are 3499211612, 581869302 and 3890346734.
- R6: `twist_done_o` is high for one cycle, together with the 624th word of a run and with no other word.
- R7: Without any further strobe, the cycle after `twist_done_o` starts a refill seeded with the last word of the finished run. The next run follows the same timing as R2 and R3, counted from the `twist_done_o` cycle.
- R8: `seed_load_i` and `seed_i` are ignored outside idle. A strobe during a run or a refill changes neither the words nor the timing.
- R9: While `rnd_vld_o` is low, `rnd_o` holds its value, which after a run is the last word of that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_i | input | 32 | Seed captured on a start strobe in idle |
| seed_load_i | input | 1 | Start strobe, honoured only in idle |
| rnd_o | output | 32 | Tempered random word |
| rnd_vld_o | output | 1 | High while `rnd_o` carries a new word |
| seed_done_o | output | 1 | One-cycle pulse at the end of a state fill |
| twist_done_o | output | 1 | One-cycle pulse with the last word of a run |

## Verification
Every output is registered, so counting from the edge that samples the strobe, `seed_done_o` is due after edge 624. The first valid word is due after edge 626 and the last one, with `twist_done_o`, after edge 1249. The refill pulse is due after edge 1873 and the second run covers edges 1875 to 2498. The bench counts edges from the strobe and samples at each falling edge. At every cycle it compares the three flags against that schedule and, on valid cycles, compares the word against a bench model of the generator. Strobes sent in the middle of a run and in the middle of a refill must leave this schedule and the data unchanged.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

   localparam int unsigned WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;

   localparam word_t FILL_MULT  = 32'd1812433253;
   localparam word_t MIX_XOR    = 32'h9908B0DF;
   localparam word_t TEMP_MASKB = 32'h9D2C5680;
   localparam word_t TEMP_MASKC = 32'hEFC60000;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FILL  = 2'd1,
      PH_GUARD = 2'd2,
      PH_MIX   = 2'd3
   } phase_e;

   // Next fill word from the previous one and its index.
   function automatic word_t fill_step(input word_t prev, input word_t idx);
      word_t folded;
      folded = prev ^ (prev >> 30);
      return (FILL_MULT * folded) + idx;
   endfunction

   // Twisted replacement for the current word.
   function automatic word_t mix_step(input word_t cur, input word_t nxt, input word_t far);
      word_t y;
      y = {cur[WORD_W-1], nxt[WORD_W-2:0]};
      return far ^ (y >> 1) ^ (y[0] ? MIX_XOR : '0);
   endfunction

   // Output tempering chain.
   function automatic word_t temper(input word_t x);
      word_t t;
      t = x ^ (x >> 11);
      t = t ^ ((t << 7) & TEMP_MASKB);
      t = t ^ ((t << 15) & TEMP_MASKC);
      t = t ^ (t >> 18);
      return t;
   endfunction

endpackage

// File: rtl/mtg_state_ram.sv
module mtg_state_ram
   import mtg_pkg::*;
#(
   parameter int unsigned DEPTH    = 624,
   parameter int unsigned RD_PORTS = 2,
   localparam int unsigned AW      = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          we,
   input  logic [AW-1:0]                 waddr,
   input  word_t                         wdata,
   input  logic [RD_PORTS-1:0][AW-1:0]   raddr,
   output logic [RD_PORTS-1:0][WORD_W-1:0] rdata
);

   word_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rdata[p] = mem[raddr[p]];
   end

endmodule

// File: rtl/mtg_seeder.sv
module mtg_seeder
   import mtg_pkg::*;
#(
   parameter int unsigned DEPTH = 624,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  word_t         seed,
   output logic          we,
   output logic [AW-1:0] waddr,
   output word_t         wdata,
   output logic          last
);

   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   logic [AW-1:0] idx;
   word_t         prev;

   always_comb begin
      we    = en;
      waddr = idx;
      last  = en && (idx == LAST_IDX);
      if (idx == '0) begin
         wdata = seed;
      end else begin
         wdata = fill_step(prev, word_t'(idx));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= '0;
         prev <= '0;
      end else if (en) begin
         prev <= wdata;
         idx  <= last ? '0 : idx + 1'b1;
      end else begin
         idx  <= '0;
      end
   end

endmodule

// File: rtl/mtg_twister.sv
module mtg_twister
   import mtg_pkg::*;
#(
   parameter int unsigned DEPTH = 624,
   parameter int unsigned OFS   = 397,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned AW1  = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prime,
   input  logic          en,
   input  word_t         rd_near,
   input  word_t         rd_far,
   output logic [AW-1:0] near_addr,
   output logic [AW-1:0] far_addr,
   output logic          we,
   output logic [AW-1:0] waddr,
   output word_t         wdata,
   output word_t         rnd_next,
   output logic          last,
   output word_t         rnd_q,
   output logic          vld_q,
   output logic          done_q
);

   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
   localparam logic [AW:0]   OFS_W    = AW1'(OFS);
   localparam logic [AW:0]   DEPTH_W  = AW1'(DEPTH);

   logic [AW-1:0] idx;
   word_t         hold;
   logic [AW:0]   far_sum;

   always_comb begin
      far_sum = {1'b0, idx} + OFS_W;
      if (far_sum >= DEPTH_W) begin
         far_addr = AW'(far_sum - DEPTH_W);
      end else begin
         far_addr = far_sum[AW-1:0];
      end
      if (prime || idx == LAST_IDX) begin
         near_addr = '0;
      end else begin
         near_addr = idx + 1'b1;
      end
      we       = en;
      waddr    = idx;
      wdata    = mix_step(hold, rd_near, rd_far);
      rnd_next = temper(wdata);
      last     = en && (idx == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx    <= '0;
         hold   <= '0;
         rnd_q  <= '0;
         vld_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         vld_q  <= en;
         done_q <= last;
         if (prime) begin
            hold <= rd_near;
            idx  <= '0;
         end else if (en) begin
            hold  <= rd_near;
            rnd_q <= rnd_next;
            idx   <= last ? '0 : idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/mtg_ctrl.sv
module mtg_ctrl
   import mtg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   fill_last,
   input  logic   mix_last,
   output phase_e phase
);

   phase_e phase_nx;

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE:  if (start)     phase_nx = PH_FILL;
         PH_FILL:  if (fill_last) phase_nx = PH_GUARD;
         PH_GUARD:                phase_nx = PH_MIX;
         PH_MIX:   if (mix_last)  phase_nx = PH_FILL;
         default:                 phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
      end else begin
         phase <= phase_nx;
      end
   end

endmodule

// File: rtl/mtg_core.sv
module mtg_core
   import mtg_pkg::*;
#(
   parameter int unsigned DEPTH = 624,
   parameter int unsigned OFS   = 397
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] seed_i,
   input  logic        seed_load_i,
   output logic [31:0] rnd_o,
   output logic        rnd_vld_o,
   output logic        seed_done_o,
   output logic        twist_done_o
);

   localparam int unsigned AW = $clog2(DEPTH);

   if (DEPTH < 3) begin : g_bad_depth
      $error("mtg_core: DEPTH must be at least 3");
   end
   if (OFS < 1 || OFS >= DEPTH) begin : g_bad_ofs
      $error("mtg_core: OFS must lie in 1..DEPTH-1");
   end

   phase_e phase;
   word_t  seed_q;
   logic   seed_done_q;

   logic          s_we, s_last;
   logic [AW-1:0] s_waddr;
   word_t         s_wdata;

   logic          t_we, t_last, t_vld, t_done;
   logic [AW-1:0] t_waddr, t_near, t_far;
   word_t         t_wdata, t_next, t_rnd;

   logic          m_we;
   logic [AW-1:0] m_waddr;
   word_t         m_wdata;
   logic [1:0][AW-1:0]     m_raddr;
   logic [1:0][WORD_W-1:0] m_rdata;

   mtg_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (seed_load_i),
      .fill_last (s_last),
      .mix_last  (t_last),
      .phase     (phase)
   );

   mtg_seeder #(.DEPTH(DEPTH)) u_seed (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (phase == PH_FILL),
      .seed  (seed_q),
      .we    (s_we),
      .waddr (s_waddr),
      .wdata (s_wdata),
      .last  (s_last)
   );

   mtg_twister #(.DEPTH(DEPTH), .OFS(OFS)) u_mix (
      .clk       (clk),
      .rst_n     (rst_n),
      .prime     (phase == PH_GUARD),
      .en        (phase == PH_MIX),
      .rd_near   (m_rdata[0]),
      .rd_far    (m_rdata[1]),
      .near_addr (t_near),
      .far_addr  (t_far),
      .we        (t_we),
      .waddr     (t_waddr),
      .wdata     (t_wdata),
      .rnd_next  (t_next),
      .last      (t_last),
      .rnd_q     (t_rnd),
      .vld_q     (t_vld),
      .done_q    (t_done)
   );

   always_comb begin
      if (phase == PH_FILL) begin
         m_we    = s_we;
         m_waddr = s_waddr;
         m_wdata = s_wdata;
      end else begin
         m_we    = t_we;
         m_waddr = t_waddr;
         m_wdata = t_wdata;
      end
      m_raddr[0] = t_near;
      m_raddr[1] = t_far;
   end

   mtg_state_ram #(.DEPTH(DEPTH), .RD_PORTS(2)) u_ram (
      .clk   (clk),
      .we    (m_we),
      .waddr (m_waddr),
      .wdata (m_wdata),
      .raddr (m_raddr),
      .rdata (m_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seed_q      <= '0;
         seed_done_q <= 1'b0;
      end else begin
         seed_done_q <= s_last;
         if (phase == PH_IDLE && seed_load_i) begin
            seed_q <= seed_i;
         end else if (t_last) begin
            seed_q <= t_next;
         end
      end
   end

   assign rnd_o        = t_rnd;
   assign rnd_vld_o    = t_vld;
   assign seed_done_o  = seed_done_q;
   assign twist_done_o = t_done;

endmodule

// File: rtl/mtg_core_chk.sv
module mtg_core_chk #(
   parameter int unsigned DEPTH = 624,
   localparam int unsigned CW   = $clog2(DEPTH + 1) + 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] rnd_o,
   input logic        rnd_vld_o,
   input logic        seed_done_o,
   input logic        twist_done_o
);

   localparam logic [CW-1:0] RUN_LEN = CW'(DEPTH);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (rnd_vld_o) begin
         run_cnt <= run_cnt + 1'b1;
      end else begin
         run_cnt <= '0;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(rnd_vld_o && seed_done_o)); // R1

   AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      seed_done_o |=> !seed_done_o); // R2

   AST_GUARD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      seed_done_o |=> !rnd_vld_o); // R3

   AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      seed_done_o |=> ##1 rnd_vld_o); // R3

   AST_RUN_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rnd_vld_o) |-> $past(seed_done_o, 2)); // R3

   AST_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rnd_vld_o) |-> run_cnt == RUN_LEN); // R4

   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_vld_o |-> run_cnt < RUN_LEN); // R4

   AST_LAST_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      twist_done_o |-> rnd_vld_o && run_cnt == RUN_LEN - 1'b1); // R6

   AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      twist_done_o |=> !rnd_vld_o); // R7

   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      !rnd_vld_o |-> $stable(rnd_o)); // R9

endmodule

bind mtg_core mtg_core_chk #(.DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rnd_o        (rnd_o),
   .rnd_vld_o    (rnd_vld_o),
   .seed_done_o  (seed_done_o),
   .twist_done_o (twist_done_o)
);

// File: tb/tb_mtg_core.sv
`timescale 1ns/1ps
module tb_mtg_core;

   localparam int N  = 624;
   localparam int MO = 397;
   localparam int S0 = N;          // fill done after this edge
   localparam int V0 = N + 2;      // first word
   localparam int V1 = 2 * N + 1;  // last word, twist done
   localparam int S1 = 3 * N + 1;  // refill done
   localparam int V2 = 3 * N + 3;
   localparam int V3 = 4 * N + 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] seed_i;
   logic        seed_load_i;
   logic [31:0] rnd_o;
   logic        rnd_vld_o;
   logic        seed_done_o;
   logic        twist_done_o;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   logic [31:0] bm    [N];
   logic [31:0] exp_a [N];
   logic [31:0] exp_b [N];

   always #2.5 clk = ~clk;

   mtg_core dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .seed_i       (seed_i),
      .seed_load_i  (seed_load_i),
      .rnd_o        (rnd_o),
      .rnd_vld_o    (rnd_vld_o),
      .seed_done_o  (seed_done_o),
      .twist_done_o (twist_done_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", tag, act, act, exp, exp);
      end
   endtask

   function automatic logic [31:0] b_temper(input logic [31:0] v);
      logic [31:0] r;
      r = v;
      r ^= r >> 11;
      r ^= (r << 7) & 32'h9D2C5680;
      r ^= (r << 15) & 32'hEFC60000;
      r ^= r >> 18;
      return r;
   endfunction

   // Reference generator: full fill, full twist, then temper the array.
   task automatic model_block(input logic [31:0] s, input bit second);
      logic [31:0] y;
      bm[0] = s;
      for (int i = 1; i < N; i++) begin
         bm[i] = 32'd1812433253 * (bm[i-1] ^ (bm[i-1] >> 30)) + i;
      end
      for (int i = 0; i < N; i++) begin
         y = (bm[i] & 32'h80000000) | (bm[(i + 1) % N] & 32'h7FFFFFFF);
         bm[i] = bm[(i + MO) % N] ^ (y >> 1) ^ ((y & 32'd1) != 0 ? 32'h9908B0DF : 32'd0);
      end
      for (int i = 0; i < N; i++) begin
         if (second) exp_b[i] = b_temper(bm[i]);
         else        exp_a[i] = b_temper(bm[i]);
      end
   endtask

   task automatic run_case(input logic [31:0] s, input bit poke);
      bit          idle_bad;
      bit          e_v, e_s, e_t;
      logic [31:0] e_w;
      rst_n = 1'b0;
      seed_load_i = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk({rnd_vld_o, seed_done_o, twist_done_o} == 3'b000, "R1 reset flags",
          {29'd0, rnd_vld_o, seed_done_o, twist_done_o}, 32'd0);
      chk(rnd_o == 32'd0, "R1 reset word", rnd_o, 32'd0);
      rst_n = 1'b1;
      idle_bad = 1'b0;
      repeat (16) begin
         @(negedge clk);
         seed_i = $urandom();
         if (rnd_vld_o || seed_done_o || twist_done_o) idle_bad = 1'b1;
      end
      chk(!idle_bad, "R1 idle without strobe", {31'd0, idle_bad}, 32'd0);

      model_block(s, 1'b0);
      model_block(exp_a[N-1], 1'b1);
      if (s == 32'd5489) begin
         chk(exp_a[0] == 32'd3499211612, "R5 model first word", exp_a[0], 32'd3499211612);
      end

      seed_i = s;
      seed_load_i = 1'b1;
      @(posedge clk);           // strobe-sampling edge
      @(negedge clk);
      seed_load_i = 1'b0;
      seed_i = ~s;
      for (int k = 1; k <= V3 + 4; k++) begin
         @(negedge clk);        // after edge k
         // R8: strobes mid-run and mid-refill must be ignored
         seed_load_i = poke && (k == 700 || k == 1500);
         seed_i = $urandom();
         e_v = (k >= V0 && k <= V1) || (k >= V2 && k <= V3);
         e_s = (k == S0) || (k == S1);
         e_t = (k == V1) || (k == V3);
         chk({rnd_vld_o, seed_done_o, twist_done_o} == {e_v, e_s, e_t},
             "R2 R3 R4 R6 R7 R8 flag schedule",
             {29'd0, rnd_vld_o, seed_done_o, twist_done_o}, {29'd0, e_v, e_s, e_t});
         if (k >= V0 && k <= V1) begin
            e_w = exp_a[k - V0];
            chk(rnd_o == e_w, "R5 R8 first run word", rnd_o, e_w);
         end else if (k >= V2 && k <= V3) begin
            e_w = exp_b[k - V2];
            chk(rnd_o == e_w, "R7 R8 refill run word", rnd_o, e_w);
         end
         if (s == 32'd5489 && k == V0)     chk(rnd_o == 32'd3499211612, "R5 word 0", rnd_o, 32'd3499211612);
         if (s == 32'd5489 && k == V0 + 1) chk(rnd_o == 32'd581869302,  "R5 word 1", rnd_o, 32'd581869302);
         if (s == 32'd5489 && k == V0 + 2) chk(rnd_o == 32'd3890346734, "R5 word 2", rnd_o, 32'd3890346734);
         if (k == V1 + 1 || k == S1) chk(rnd_o == exp_a[N-1], "R9 held word", rnd_o, exp_a[N-1]);
         if (k == V3 + 3)            chk(rnd_o == exp_b[N-1], "R9 held word", rnd_o, exp_b[N-1]);
      end
      seed_load_i = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected at most 50000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      seed_i = 32'd0;
      seed_load_i = 1'b0;
      void'($urandom(32'h1F2E3D4C));
      run_case(32'd5489, 1'b1);
      run_case(32'd0, 1'b0);
      run_case(32'hFFFFFFFF, 1'b1);
      repeat (2) run_case($urandom(), 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule